// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block sits in front of a small word-addressed memory shared by several cores and gives each of them load-linked and store-conditional semantics. Every core owns a request port carrying an operation code, a word address, write data and a valid flag. The core holds its request until the unit answers with a one-cycle done pulse, along with read data and, for a conditional store, a success flag.

Every access is taken in a single global order: a round-robin arbiter grants at most one core per cycle. The conditional store is judged at the moment of its grant, against a reservation table that all cores share. A winning conditional store writes memory and clears every other core's reservation on that word. A losing one writes nothing. In both cases the issuing core waits a fixed number of cycles before it gets its result. Software builds locks by spinning on a load-linked read followed by a conditional store, and retries when the result is 0.

Top module: `atomic_resv_unit`

## Requirements
- R1: A load-linked request (op code 2) returns the addressed memory word and arms the issuing core's single reservation on that address. An earlier reservation of the same core is replaced.
- R2: A plain load (op code 0) returns the addressed word and a plain store (op code 1) writes its data. Each answers with done in the same cycle as its grant, so an uncontended request is done in the cycle it is first presented. The store returns 0 as read data.
- R3: A conditional store (op code 3) succeeds when the core holds a reservation on that address at grant time. It then writes its data, raises the success flag, and returns read data 1.
- R4: A failed conditional store leaves memory unchanged, keeps the success flag low, and returns read data 0.
- R5: A conditional store fails when the core holds no reservation, or when the reservation is for a different address.
- R6: A conditional store raises done exactly SC_LAT cycles after its grant cycle (SC_LAT is at least 2), and never earlier.
- R7: Any memory write by one core clears the reservations of all other cores on that word, whether the write comes from a plain store or a successful conditional store.
- R8: A conditional store clears the issuing core's own reservation, whether it succeeds or fails.
- R9: At most one core is granted per cycle. When several cores hold reservations on one word and issue conditional stores together, exactly one of them succeeds.
- R10: Reset clears all memory words to 0, drops all reservations and pending stalls, and leaves done low while no request is valid.
- R11: A mutex word (0 unlocked, 1 locked) taken with load-linked/conditional-store spin loops on all cores keeps a shared counter exact. Every increment made under the lock is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core request valid, held until done |
| req_op | input | 2*NCORE | Per-core op: 0 load, 1 store, 2 load-linked, 3 conditional store |
| req_addr | input | AW*NCORE | Per-core word address |
| req_wdata | input | DW*NCORE | Per-core write data |
| resp_done | output | NCORE | Per-core one-cycle completion pulse |
| resp_rdata | output | DW*NCORE | Per-core read data, valid with done |
| resp_sc_ok | output | NCORE | Conditional store succeeded, valid with done |

## Verification
A stale reservation, one that should have been cleared by another core's write or by the core's own conditional store, shows up at the next conditional store from that core. That store reports success and overwrites a word it should have left alone, and a plain load exposes the damage in the following cycle. A broken arbiter or decision point lets two simultaneous conditional stores both succeed. The mutex run then loses counter increments, so the final counter value differs from cores times iterations. A wrong stall counter moves the done pulse away from SC_LAT cycles after the grant, and the bench sees this on the very first isolated conditional store.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } mem_op_e;

    typedef struct packed {
        logic rd;     // returns a memory word
        logic wr;     // unconditional write
        logic link;   // arms a reservation
        logic cond;   // conditional store
    } op_dec_t;

    function automatic op_dec_t decode_op(input mem_op_e op, input logic en);
        op_dec_t d;
        d.rd   = en && (op == OP_LOAD || op == OP_LINK);
        d.wr   = en && (op == OP_STORE);
        d.link = en && (op == OP_LINK);
        d.cond = en && (op == OP_COND);
        return d;
    endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    req,
    output logic [N-1:0]    grant,
    output logic [IDXW-1:0] grant_idx,
    output logic            grant_any
);
    logic [IDXW-1:0] ptr;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int off = 0; off < N; off++) begin
            int cand;
            cand = (int'(ptr) + off) % N;
            if (!grant_any && req[cand]) begin
                grant_any   = 1'b1;
                grant_idx   = IDXW'(cand);
                grant[cand] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (grant_any) begin
            ptr <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + 1'b1;
        end
    end
endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int N    = 4,
    parameter int AW   = 6,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            g_any,
    input  logic [IDXW-1:0] g_idx,
    input  logic [AW-1:0]   g_addr,
    input  logic            g_link,
    input  logic            g_cond,
    input  logic            wr_commit,
    output logic            sc_pass,
    output logic [N-1:0]    rv_valid,
    output logic [N*AW-1:0] rv_addr_flat
);
    logic [AW-1:0] rv_addr [N];

    always_comb begin
        sc_pass = rv_valid[g_idx] && (rv_addr[g_idx] == g_addr);
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_ent
            assign rv_addr_flat[k*AW +: AW] = rv_addr[k];

            always_ff @(posedge clk) begin
                if (rst) begin
                    rv_valid[k] <= 1'b0;
                    rv_addr[k]  <= '0;
                end else if (g_any) begin
                    if (int'(g_idx) == k) begin
                        if (g_link) begin
                            rv_valid[k] <= 1'b1;
                            rv_addr[k]  <= g_addr;
                        end else if (g_cond) begin
                            rv_valid[k] <= 1'b0;
                        end
                    end else if (wr_commit && rv_valid[k] && rv_addr[k] == g_addr) begin
                        rv_valid[k] <= 1'b0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sc_stall.sv
module sc_stall #(
    parameter int N   = 4,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] start,
    input  logic         pass_in,
    output logic [N-1:0] pending,
    output logic [N-1:0] fin,
    output logic [N-1:0] result
);
    localparam int CW = (LAT > 1) ? $clog2(LAT + 1) : 1;

    generate
        for (genvar i = 0; i < N; i++) begin : g_core
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pending[i] <= 1'b0;
                    cnt        <= '0;
                    result[i]  <= 1'b0;
                end else if (start[i]) begin
                    pending[i] <= 1'b1;
                    cnt        <= CW'(LAT - 1);
                    result[i]  <= pass_in;
                end else if (pending[i]) begin
                    if (cnt == '0) pending[i] <= 1'b0;
                    else           cnt        <= cnt - 1'b1;
                end
            end

            assign fin[i] = pending[i] && (cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/word_mem.sv
module word_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) words[j] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit #(
    parameter int NCORE  = 4,
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int SC_LAT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [2*NCORE-1:0]  req_op,
    input  logic [AW*NCORE-1:0] req_addr,
    input  logic [DW*NCORE-1:0] req_wdata,
    output logic [NCORE-1:0]    resp_done,
    output logic [DW*NCORE-1:0] resp_rdata,
    output logic [NCORE-1:0]    resp_sc_ok
);
    import rsv_pkg::*;

    localparam int IDXW = (NCORE > 1) ? $clog2(NCORE) : 1;

    logic [NCORE-1:0]    eligible;
    logic [NCORE-1:0]    grant_vec;
    logic [IDXW-1:0]     grant_idx;
    logic                grant_any;
    mem_op_e             g_op;
    logic [AW-1:0]       g_addr;
    logic [DW-1:0]       g_wdata;
    op_dec_t             dec;
    logic                sc_pass;
    logic                mem_we;
    logic [DW-1:0]       mem_rdata;
    logic [NCORE-1:0]    resv_valid;
    logic [NCORE*AW-1:0] resv_addr_flat;
    logic [NCORE-1:0]    sc_start;
    logic [NCORE-1:0]    sc_pending;
    logic [NCORE-1:0]    sc_fin;
    logic [NCORE-1:0]    sc_res;

    assign eligible = req_valid & ~sc_pending;

    rr_arbiter #(.N(NCORE), .IDXW(IDXW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (eligible),
        .grant     (grant_vec),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    always_comb begin
        g_op    = mem_op_e'(req_op[int'(grant_idx)*2 +: 2]);
        g_addr  = req_addr[int'(grant_idx)*AW +: AW];
        g_wdata = req_wdata[int'(grant_idx)*DW +: DW];
        dec     = decode_op(g_op, grant_any);
        mem_we  = dec.wr || (dec.cond && sc_pass);
    end

    resv_table #(.N(NCORE), .AW(AW), .IDXW(IDXW)) u_resv (
        .clk          (clk),
        .rst          (rst),
        .g_any        (grant_any),
        .g_idx        (grant_idx),
        .g_addr       (g_addr),
        .g_link       (dec.link),
        .g_cond       (dec.cond),
        .wr_commit    (mem_we),
        .sc_pass      (sc_pass),
        .rv_valid     (resv_valid),
        .rv_addr_flat (resv_addr_flat)
    );

    word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (g_addr),
        .wdata (g_wdata),
        .rdata (mem_rdata)
    );

    assign sc_start = dec.cond ? grant_vec : '0;

    sc_stall #(.N(NCORE), .LAT(SC_LAT)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .start   (sc_start),
        .pass_in (sc_pass),
        .pending (sc_pending),
        .fin     (sc_fin),
        .result  (sc_res)
    );

    generate
        for (genvar i = 0; i < NCORE; i++) begin : g_resp
            always_comb begin
                resp_done[i]  = (grant_vec[i] && !dec.cond) || sc_fin[i];
                resp_sc_ok[i] = sc_fin[i] && sc_res[i];
                if (sc_fin[i])
                    resp_rdata[i*DW +: DW] = DW'(sc_res[i]);
                else if (grant_vec[i] && dec.rd)
                    resp_rdata[i*DW +: DW] = mem_rdata;
                else
                    resp_rdata[i*DW +: DW] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/atomic_resv_checker.sv
module atomic_resv_checker #(
    parameter int NCORE  = 4,
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int SC_LAT = 3,
    parameter int IDXW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [2*NCORE-1:0]  req_op,
    input logic [NCORE-1:0]    resp_done,
    input logic [DW*NCORE-1:0] resp_rdata,
    input logic [NCORE-1:0]    resp_sc_ok,
    input logic [NCORE-1:0]    grant_vec,
    input logic [IDXW-1:0]     grant_idx,
    input logic [NCORE-1:0]    sc_pending,
    input logic [NCORE-1:0]    resv_valid,
    input logic [NCORE*AW-1:0] resv_addr_flat,
    input logic                mem_we,
    input logic [AW-1:0]       g_addr
);
    assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (sc_pending == '0 && resv_valid == '0));

    generate
        for (genvar i = 0; i < NCORE; i++) begin : g_chk
            assert_ok_result_R3: assert property (@(posedge clk) disable iff (rst)
                resp_sc_ok[i] |-> (resp_done[i] && resp_rdata[i*DW +: DW] == DW'(1)));

            assert_no_early_done_R6: assert property (@(posedge clk) disable iff (rst)
                (grant_vec[i] && req_op[i*2 +: 2] == 2'd3) |=> !resp_done[i]);

            assert_own_resv_drop_R8: assert property (@(posedge clk) disable iff (rst)
                (grant_vec[i] && req_op[i*2 +: 2] == 2'd3) |=> !resv_valid[i]);

            assert_fail_no_write_R5: assert property (@(posedge clk) disable iff (rst)
                (grant_vec[i] && req_op[i*2 +: 2] == 2'd3 && !resv_valid[i]) |-> !mem_we);

            assert_snoop_clear_R7: assert property (@(posedge clk) disable iff (rst)
                (mem_we && int'(grant_idx) != i) |=>
                    !(resv_valid[i] && resv_addr_flat[i*AW +: AW] == $past(g_addr)));
        end
    endgenerate
endmodule

bind atomic_resv_unit atomic_resv_checker #(
    .NCORE(NCORE), .AW(AW), .DW(DW), .SC_LAT(SC_LAT), .IDXW(IDXW)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_op         (req_op),
    .resp_done      (resp_done),
    .resp_rdata     (resp_rdata),
    .resp_sc_ok     (resp_sc_ok),
    .grant_vec      (grant_vec),
    .grant_idx      (grant_idx),
    .sc_pending     (sc_pending),
    .resv_valid     (resv_valid),
    .resv_addr_flat (resv_addr_flat),
    .mem_we         (mem_we),
    .g_addr         (g_addr)
);

// File: tb/test_atomic_resv_unit.sv
module test_atomic_resv_unit;
    localparam int NC   = 4;
    localparam int AW   = 6;
    localparam int DW   = 32;
    localparam int LAT  = 3;
    localparam int ITER = 6;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

    typedef struct packed {
        logic [1:0]    core;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic          ok;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VT [NV] = '{
        '{2'd0, LD, 6'd5,  32'h0,  32'h0,  1'b0},  // R10 memory starts at 0
        '{2'd0, ST, 6'd5,  32'h11, 32'h0,  1'b0},  // R2
        '{2'd1, LD, 6'd5,  32'h0,  32'h11, 1'b0},  // R2
        '{2'd1, LL, 6'd5,  32'h0,  32'h11, 1'b0},  // R1
        '{2'd1, SC, 6'd5,  32'h22, 32'h1,  1'b1},  // R3
        '{2'd0, LD, 6'd5,  32'h0,  32'h22, 1'b0},  // R3 write landed
        '{2'd1, SC, 6'd5,  32'h33, 32'h0,  1'b0},  // R8 own reservation gone
        '{2'd2, LD, 6'd5,  32'h0,  32'h22, 1'b0},  // R4 no write
        '{2'd2, SC, 6'd7,  32'h44, 32'h0,  1'b0},  // R5 no reservation
        '{2'd2, LL, 6'd7,  32'h0,  32'h0,  1'b0},  // R1
        '{2'd2, SC, 6'd8,  32'h55, 32'h0,  1'b0},  // R5 other address
        '{2'd3, LD, 6'd8,  32'h0,  32'h0,  1'b0},  // R4
        '{2'd2, LL, 6'd7,  32'h0,  32'h0,  1'b0},
        '{2'd3, LL, 6'd7,  32'h0,  32'h0,  1'b0},
        '{2'd0, ST, 6'd7,  32'h66, 32'h0,  1'b0},  // R7 plain write
        '{2'd2, SC, 6'd7,  32'h77, 32'h0,  1'b0},  // R7
        '{2'd3, SC, 6'd7,  32'h78, 32'h0,  1'b0},  // R7
        '{2'd3, LL, 6'd9,  32'h0,  32'h0,  1'b0},
        '{2'd3, LL, 6'd7,  32'h0,  32'h66, 1'b0},  // R1 replaces reservation
        '{2'd3, SC, 6'd9,  32'h99, 32'h0,  1'b0}   // R1 old address dropped
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NC-1:0]       req_valid;
    logic [2*NC-1:0]     req_op;
    logic [AW*NC-1:0]    req_addr;
    logic [DW*NC-1:0]    req_wdata;
    logic [NC-1:0]       resp_done;
    logic [DW*NC-1:0]    resp_rdata;
    logic [NC-1:0]       resp_sc_ok;

    logic          b_v  [NC];
    logic [1:0]    b_op [NC];
    logic [AW-1:0] b_ad [NC];
    logic [DW-1:0] b_wd [NC];

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #10 clk = ~clk;  // 50 MHz

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            req_valid[c]          = b_v[c];
            req_op[c*2 +: 2]      = b_op[c];
            req_addr[c*AW +: AW]  = b_ad[c];
            req_wdata[c*DW +: DW] = b_wd[c];
        end
    end

    atomic_resv_unit #(.NCORE(NC), .AW(AW), .DW(DW), .SC_LAT(LAT)) i_atomic_resv_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata),
        .resp_sc_ok (resp_sc_ok)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, want);
        end
    endtask

    task automatic run_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                          output logic ok, output int cyc);
        @(negedge clk);
        b_v[c] = 1'b1; b_op[c] = op; b_ad[c] = a; b_wd[c] = wd;
        cyc = 0;
        #1;
        while (!resp_done[c]) begin
            @(negedge clk);
            cyc++;
            #1;
        end
        rd = resp_rdata[c*DW +: DW];
        ok = resp_sc_ok[c];
        @(posedge clk);
        #1;
        b_v[c] = 1'b0;
    endtask

    task automatic worker(input int c);
        logic [DW-1:0] rd;
        logic ok;
        int cyc;
        for (int k = 0; k < ITER; k++) begin
            ok = 1'b0;
            while (!ok) begin
                run_op(c, LL, 6'd31, '0, rd, ok, cyc);
                if (rd == '0) run_op(c, SC, 6'd31, 32'd1, rd, ok, cyc);
                else ok = 1'b0;
            end
            run_op(c, LD, 6'd30, '0, rd, ok, cyc);
            run_op(c, ST, 6'd30, rd + 1, rd, ok, cyc);
            run_op(c, ST, 6'd31, '0, rd, ok, cyc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        logic ok;
        int cyc;
        int n_ok;
        int winner;
        logic [DW-1:0] sim_rd [NC];
        logic          sim_ok [NC];

        for (int c = 0; c < NC; c++) begin
            b_v[c] = 1'b0; b_op[c] = LD; b_ad[c] = '0; b_wd[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 done low in reset", DW'(resp_done), '0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R10 done low after reset", DW'(resp_done), '0);

        // vector table walk, one core at a time
        for (int v = 0; v < NV; v++) begin
            run_op(int'(VT[v].core), VT[v].op, VT[v].addr, VT[v].wd, rd, ok, cyc);
            check($sformatf("R1-vector %0d rdata", v), rd, VT[v].rd);
            check($sformatf("R3 vector %0d sc flag", v), DW'(ok), DW'(VT[v].ok));
            if (VT[v].op == SC) check($sformatf("R6 vector %0d latency", v), DW'(cyc), DW'(LAT));
            else                check($sformatf("R2 vector %0d latency", v), DW'(cyc), 0);
        end
        run_op(0, LD, 6'd7, '0, rd, ok, cyc);
        check("R7 word after failed stores", rd, 32'h66);
        run_op(0, LD, 6'd9, '0, rd, ok, cyc);
        check("R5 word untouched", rd, 32'h0);

        // simultaneous conditional stores to one word
        for (int c = 0; c < NC; c++) run_op(c, LL, 6'd20, '0, rd, ok, cyc);
        for (int c = 0; c < NC; c++) begin
            automatic int cc = c;
            fork
                begin
                    logic [DW-1:0] r;
                    logic o;
                    int y;
                    run_op(cc, SC, 6'd20, DW'(100 + cc), r, o, y);
                    sim_rd[cc] = r;
                    sim_ok[cc] = o;
                end
            join_none
        end
        wait fork;
        n_ok = 0;
        winner = 0;
        for (int c = 0; c < NC; c++) if (sim_ok[c]) begin n_ok++; winner = c; end
        check("R9 single winner", DW'(n_ok), 1);
        check("R4 loser rdata", sim_rd[(winner + 1) % NC], '0);
        run_op(0, LD, 6'd20, '0, rd, ok, cyc);
        check("R9 winner data in memory", rd, DW'(100 + winner));

        // mutex-protected counter on all cores
        for (int c = 0; c < NC; c++) begin
            automatic int cc = c;
            fork
                worker(cc);
            join_none
        end
        wait fork;
        run_op(1, LD, 6'd30, '0, rd, ok, cyc);
        check("R11 counter total", rd, DW'(NC * ITER));
        run_op(1, LD, 6'd31, '0, rd, ok, cyc);
        check("R11 lock released", rd, '0);

        // reset clears memory and reservations
        run_op(2, ST, 6'd40, 32'h5A, rd, ok, cyc);
        run_op(2, LL, 6'd40, '0, rd, ok, cyc);
        check("R1 load-linked before reset", rd, 32'h5A);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 done low after second reset", DW'(resp_done), '0);
        run_op(2, LD, 6'd40, '0, rd, ok, cyc);
        check("R10 memory cleared", rd, '0);
        run_op(2, SC, 6'd40, 32'h77, rd, ok, cyc);
        check("R10 reservation cleared", DW'(ok), '0);
        run_op(3, LD, 6'd40, '0, rd, ok, cyc);
        check("R4 word stays zero", rd, '0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule